// File: doc/BRIEF.md
# Serial-Bus Wiper Register Target

This block is a clocked I2C target serving a tiny register space for a digitally set potentiometer. It keeps a volatile 7-bit wiper position and a mirror of the nonvolatile start-up position. Both sit at register address 0. A one-bit volatile selector at address 2 decides which of the two an access to address 0 reaches. SCL and SDA are synchronised into the system clock domain and their edges are detected there. The block answers the identification byte, write transactions (identification, register address, data) and combined reads (identification, register address, repeated START, identification, data). It pulls SDA low through an open-drain enable.

When the selector is clear, a data write to address 0 moves the wiper and refreshes the start-up value at once. The write only arms a store. The STOP that closes the transaction then raises a one-cycle request to the nonvolatile controller, carrying the start-up value. While that controller reports busy, the block ignores the bus entirely and keeps SDA released.

Top module: `i2c_wiper_regs`

## Requirements
- R1: After reset the wiper output is 40h, SDA is released, no store request is raised and the selector is clear, so a read of address 0 returns 40h.
- R2: An identification byte whose upper five bits are 01010, whose next two bits equal the strap inputs (first strap bit 1, then bit 0) and whose LSB is the direction (1 read, 0 write) is acknowledged. Any other identification byte is not acknowledged, and the block then ignores the bus until the next START.
- R3: With the selector clear, a data byte written to address 0 sets both the wiper and the start-up value to its low seven bits; bit 7 is dropped.
- R4: Written data takes effect on the SCL falling edge that ends the data LSB. The acknowledge for that byte begins on the same edge; before that edge the old value remains.
- R5: A STOP after an armed address-0 write raises the store request for exactly one clock with the new start-up value on the store data output. A transaction stopped before its data byte raises no request.
- R6: With the selector set, a write of address 0 changes only the wiper, raises no store request, and a read of address 0 returns the wiper.
- R7: With the selector clear, a read of address 0 returns the start-up value, zero-extended to eight bits.
- R8: Address 2 stores only data bit 7 and reads back as that bit followed by seven zeros.
- R9: Writes to address 1 (and any other unused address) are acknowledged and discarded; reads of them return 00h.
- R10: While the busy input is high, SDA stays released and every bus transition is ignored.
- R11: Read data is sent MSB first. A master acknowledge makes the block send the same register again; a master no-acknowledge ends the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| strap | input | 2 | Address straps compared with identification bits 2:1 |
| nv_busy | input | 1 | Nonvolatile controller busy; the bus is ignored while high |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_pos | output | 7 | Current wiper position |
| nv_store_req | output | 1 | One-cycle request to store the start-up value |
| nv_store_data | output | 7 | Start-up value to be stored |

## Verification
Two things happen in the same clock: the data commit and the start of the acknowledge. The SCL fall that ends the data LSB both updates the wiper and starts pulling SDA low. The bench samples the wiper during the high phase of the last data bit, when the old value is expected. It samples again during the acknowledge clock, when both the new value and the acknowledge must be present together. A STOP that lands while a store is armed is judged by counting request pulses across transactions. Some of those transactions are aborted early and some use the volatile selector.

// File: rtl/wpr_pkg.sv
package wpr_pkg;
  localparam logic [4:0] ID_PREFIX = 5'b01010;
  localparam int         REG_POS   = 0;
  localparam int         REG_SEL   = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ID,
    ST_ID_ACK,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_SKIP
  } bus_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync, sda_sync;
  logic         scl_q, sda_q;
  logic         scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[TOP-1:0], scl_in};
      sda_sync <= {sda_sync[TOP-1:0], sda_in};
      scl_q    <= scl_sync[TOP];
      sda_q    <= sda_sync[TOP];
    end
  end

  assign scl_lvl   = scl_sync[TOP];
  assign sda_lvl   = sda_sync[TOP];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/wiper_regfile.sv
module wiper_regfile
  import wpr_pkg::*;
#(
  parameter int           WIPER_W   = 7,
  parameter int           DATA_W    = 8,
  parameter logic [6:0]   RESET_POS = 7'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [WIPER_W-1:0] wiper,
  output logic [WIPER_W-1:0] ivr,
  output logic               sel_vol,
  output logic               nv_target
);
  localparam int PAD = DATA_W - WIPER_W;

  logic hit_pos, hit_sel;

  assign hit_pos   = (addr == DATA_W'(REG_POS));
  assign hit_sel   = (addr == DATA_W'(REG_SEL));
  assign nv_target = hit_pos & ~sel_vol;

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper   <= WIPER_W'(RESET_POS);
      ivr     <= WIPER_W'(RESET_POS);
      sel_vol <= 1'b0;
    end else if (wr_en) begin
      if (hit_pos) begin
        wiper <= wdata[WIPER_W-1:0];
        if (!sel_vol) ivr <= wdata[WIPER_W-1:0];
      end else if (hit_sel) begin
        sel_vol <= wdata[DATA_W-1];
      end
    end
  end

  always_comb begin
    if (hit_pos)      rdata = sel_vol ? {{PAD{1'b0}}, wiper} : {{PAD{1'b0}}, ivr};
    else if (hit_sel) rdata = {sel_vol, {(DATA_W-1){1'b0}}};
    else              rdata = '0;
  end
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import wpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        strap,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              nv_busy,
  input  logic [DATA_W-1:0] rdata,
  input  logic              nv_target,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              sda_low,
  output logic              nv_req
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  bus_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg, txreg, ptr;
  logic              byte_full, rw, armed, master_ack;
  logic              id_ok;

  assign id_ok     = (shreg[7:3] == ID_PREFIX) && (shreg[2:1] == strap);
  assign reg_addr  = ptr;
  assign reg_wdata = shreg;
  assign reg_wr_en = !nv_busy && !stop_det && !start_det &&
                     state == ST_WDATA && byte_full && scl_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      txreg      <= '0;
      ptr        <= '0;
      byte_full  <= 1'b0;
      rw         <= 1'b0;
      armed      <= 1'b0;
      master_ack <= 1'b0;
      sda_low    <= 1'b0;
      nv_req     <= 1'b0;
    end else begin
      nv_req <= 1'b0;
      if (nv_busy) begin
        state     <= ST_IDLE;
        sda_low   <= 1'b0;
        byte_full <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_low   <= 1'b0;
        byte_full <= 1'b0;
        if (armed) begin
          nv_req <= 1'b1;
          armed  <= 1'b0;
        end
      end else if (start_det) begin
        state     <= ST_ID;
        cnt       <= '0;
        byte_full <= 1'b0;
        sda_low   <= 1'b0;
      end else begin
        case (state)
          ST_ID, ST_ADDR, ST_WDATA: begin
            if (scl_rise && !byte_full) begin
              shreg <= {shreg[DATA_W-2:0], sda_lvl};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) byte_full <= 1'b1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              cnt       <= '0;
              if (state == ST_ID) begin
                if (id_ok) begin
                  sda_low <= 1'b1;
                  rw      <= shreg[0];
                  state   <= ST_ID_ACK;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (state == ST_ADDR) begin
                ptr     <= shreg;
                sda_low <= 1'b1;
                state   <= ST_ADDR_ACK;
              end else begin
                sda_low <= 1'b1;
                state   <= ST_WDATA_ACK;
                if (nv_target) armed <= 1'b1;
              end
            end
          end
          ST_ID_ACK: begin
            if (scl_fall) begin
              if (rw) begin
                txreg   <= rdata;
                sda_low <= ~rdata[DATA_W-1];
                cnt     <= '0;
                state   <= ST_RDATA;
              end else begin
                sda_low <= 1'b0;
                state   <= ST_ADDR;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              state   <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_low <= 1'b0;
              state   <= ST_SKIP;
            end
          end
          ST_RDATA: begin
            if (scl_rise && !byte_full) begin
              cnt <= cnt + 1'b1;
              if (cnt == LAST) byte_full <= 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                byte_full <= 1'b0;
                sda_low   <= 1'b0;
                state     <= ST_RDATA_ACK;
              end else begin
                txreg   <= {txreg[DATA_W-2:0], 1'b0};
                sda_low <= ~txreg[DATA_W-2];
              end
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise) begin
              master_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (master_ack) begin
                txreg   <= rdata;
                sda_low <= ~rdata[DATA_W-1];
                cnt     <= '0;
                state   <= ST_RDATA;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wiper_regs.sv
module i2c_wiper_regs #(
  parameter int         WIPER_W     = 7,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] RESET_POS   = 7'h40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [1:0]         strap,
  input  logic               nv_busy,
  output logic               sda_drive_low,
  output logic [WIPER_W-1:0] wiper_pos,
  output logic               nv_store_req,
  output logic [WIPER_W-1:0] nv_store_data
);
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              reg_wr_en, nv_target, sel_vol;
  logic [DATA_W-1:0] reg_addr, reg_wdata, rdata;
  logic [WIPER_W-1:0] ivr_val;

  i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_target_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .strap(strap), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .nv_busy(nv_busy), .rdata(rdata),
    .nv_target(nv_target), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sda_low(sda_drive_low), .nv_req(nv_store_req)
  );

  wiper_regfile #(.WIPER_W(WIPER_W), .DATA_W(DATA_W), .RESET_POS(RESET_POS)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(rdata), .wiper(wiper_pos), .ivr(ivr_val),
    .sel_vol(sel_vol), .nv_target(nv_target)
  );

  assign nv_store_data = ivr_val;
endmodule

// File: rtl/wiper_regs_checker.sv
module wiper_regs_checker #(
  parameter int         WIPER_W   = 7,
  parameter logic [6:0] RESET_POS = 7'h40
) (
  input logic               clk,
  input logic               rst,
  input logic               nv_busy,
  input logic               sda_drive_low,
  input logic               nv_store_req,
  input logic [WIPER_W-1:0] wiper_pos,
  input logic [WIPER_W-1:0] ivr_val,
  input logic               sel_vol,
  input logic               scl_fall,
  input logic               stop_det
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wiper_pos == WIPER_W'(RESET_POS)) && !sda_drive_low && !nv_store_req);

  a_r10_busy_release: assert property (@(posedge clk) disable iff (rst)
    $past(nv_busy) |-> !sda_drive_low);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    nv_store_req |=> !nv_store_req);

  a_r5_req_from_stop: assert property (@(posedge clk) disable iff (rst)
    nv_store_req |-> $past(stop_det));

  a_r4_commit_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper_pos) |-> $past(scl_fall));

  a_r6_ivr_needs_clear_sel: assert property (@(posedge clk) disable iff (rst)
    !$stable(ivr_val) |-> !$past(sel_vol));
endmodule

bind i2c_wiper_regs wiper_regs_checker #(.WIPER_W(WIPER_W), .RESET_POS(RESET_POS)) u_chk (
  .clk(clk), .rst(rst), .nv_busy(nv_busy), .sda_drive_low(sda_drive_low),
  .nv_store_req(nv_store_req), .wiper_pos(wiper_pos), .ivr_val(ivr_val),
  .sel_vol(sel_vol), .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/sim_i2c_wiper_regs.sv
module sim_i2c_wiper_regs;
  localparam int Q = 8;
  localparam logic [7:0] ID_W = 8'h54;
  localparam logic [7:0] ID_R = 8'h55;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       nv_busy = 1'b0;
  logic [1:0] strap = 2'b10;
  logic       sda_drive_low, nv_store_req;
  logic [6:0] wiper_pos, nv_store_data;
  logic       sda_line;

  int n_checks = 0;
  int n_fail   = 0;
  int req_cnt  = 0;
  int busy_drv = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_drive_low;

  i2c_wiper_regs u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .strap(strap),
    .nv_busy(nv_busy), .sda_drive_low(sda_drive_low), .wiper_pos(wiper_pos),
    .nv_store_req(nv_store_req), .nv_store_data(nv_store_data)
  );

  always @(posedge clk) begin
    if (!rst && nv_store_req) req_cnt <= req_cnt + 1;
    if (!rst && nv_busy && sda_drive_low) busy_drv <= busy_drv + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack,
                           output logic [6:0] w_mid, output logic [6:0] w_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q);
      if (i == 0) w_mid = wiper_pos;
      tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    w_ack = wiper_pos;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q); scl = 1'b0; tick(Q);
    end
    sda_m = ~mack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [7:0] data,
                           output bit a0, output bit a1, output bit a2,
                           output logic [6:0] w_mid, output logic [6:0] w_ack);
    logic [6:0] m, k;
    bus_start();
    send_byte(ID_W, a0, m, k);
    send_byte(addr, a1, m, k);
    send_byte(data, a2, w_mid, w_ack);
    bus_stop();
    tick(4*Q);
  endtask

  task automatic read_reg(input logic [7:0] addr, input bit second,
                          output logic [7:0] d0, output logic [7:0] d1);
    bit a;
    logic [6:0] m, k;
    bus_start();
    send_byte(ID_W, a, m, k);
    send_byte(addr, a, m, k);
    bus_start();
    send_byte(ID_R, a, m, k);
    recv_byte(second, d0);
    d1 = 8'h00;
    if (second) recv_byte(1'b0, d1);
    bus_stop();
    tick(4*Q);
  endtask

  task automatic t_reset();
    logic [7:0] d0, d1;
    check(wiper_pos == 7'h40, "R1 wiper", wiper_pos, 7'h40);
    check(!sda_drive_low, "R1 sda released", sda_drive_low, 0);
    check(req_cnt == 0, "R1 no request", req_cnt, 0);
    read_reg(8'h00, 1'b0, d0, d1);
    check(d0 == 8'h40, "R1 read addr0 after reset", d0, 8'h40);
  endtask

  task automatic t_store_write();
    bit a0, a1, a2;
    logic [6:0] wm, wa;
    logic [7:0] d0, d1;
    int r0;
    r0 = req_cnt;
    write_reg(8'h00, 8'hF7, a0, a1, a2, wm, wa);
    check(a0 && a1 && a2, "R2 valid id and bytes acked", {a0, a1, a2}, 3'b111);
    check(wm == 7'h40, "R4 old value before LSB fall", wm, 7'h40);
    check(wa == 7'h77, "R4 new value during ack", wa, 7'h77);
    check(wiper_pos == 7'h77, "R3 wiper low seven bits", wiper_pos, 7'h77);
    check(req_cnt == r0 + 1, "R5 one request after stop", req_cnt, r0 + 1);
    check(nv_store_data == 7'h77, "R5 store data", nv_store_data, 7'h77);
    read_reg(8'h00, 1'b0, d0, d1);
    check(d0 == 8'h77, "R7 read start-up value", d0, 8'h77);
  endtask

  task automatic t_volatile();
    bit a0, a1, a2;
    logic [6:0] wm, wa;
    logic [7:0] d0, d1;
    int r0;
    write_reg(8'h02, 8'h80, a0, a1, a2, wm, wa);
    r0 = req_cnt;
    write_reg(8'h00, 8'h12, a0, a1, a2, wm, wa);
    check(wiper_pos == 7'h12, "R6 volatile write moves wiper", wiper_pos, 7'h12);
    check(req_cnt == r0, "R6 no request on volatile write", req_cnt, r0);
    read_reg(8'h00, 1'b1, d0, d1);
    check(d0 == 8'h12, "R6 read returns wiper", d0, 8'h12);
    check(d1 == 8'h12, "R11 ack repeats same register", d1, 8'h12);
    read_reg(8'h02, 1'b0, d0, d1);
    check(d0 == 8'h80, "R8 selector reads 80h", d0, 8'h80);
    write_reg(8'h02, 8'h7F, a0, a1, a2, wm, wa);
    read_reg(8'h02, 1'b0, d0, d1);
    check(d0 == 8'h00, "R8 only bit 7 kept", d0, 8'h00);
    read_reg(8'h00, 1'b0, d0, d1);
    check(d0 == 8'h77, "R7 start-up value untouched by volatile write", d0, 8'h77);
    check(wiper_pos == 7'h12, "R6 wiper kept", wiper_pos, 7'h12);
  endtask

  task automatic t_reserved();
    bit a0, a1, a2;
    logic [6:0] wm, wa;
    logic [7:0] d0, d1;
    int r0;
    r0 = req_cnt;
    write_reg(8'h01, 8'h55, a0, a1, a2, wm, wa);
    check(a2, "R9 reserved write acked", a2, 1);
    check(wiper_pos == 7'h12, "R9 reserved write discarded", wiper_pos, 7'h12);
    check(req_cnt == r0, "R9 no request", req_cnt, r0);
    read_reg(8'h01, 1'b0, d0, d1);
    check(d0 == 8'h00, "R9 reserved reads zero", d0, 8'h00);
  endtask

  task automatic t_bad_id();
    bit a;
    logic [6:0] m, k;
    bus_start();
    send_byte(8'h52, a, m, k);
    check(!a, "R2 wrong strap not acked", a, 0);
    send_byte(8'h00, a, m, k);
    check(!a, "R2 ignored after mismatch", a, 0);
    send_byte(8'h33, a, m, k);
    bus_stop();
    check(wiper_pos == 7'h12, "R2 wiper unchanged", wiper_pos, 7'h12);
    bus_start();
    send_byte(8'hA4, a, m, k);
    check(!a, "R2 wrong prefix not acked", a, 0);
    bus_stop();
    tick(4*Q);
  endtask

  task automatic t_abort();
    bit a;
    logic [6:0] m, k;
    int r0;
    r0 = req_cnt;
    bus_start();
    send_byte(ID_W, a, m, k);
    send_byte(8'h00, a, m, k);
    bus_stop();
    tick(4*Q);
    check(req_cnt == r0, "R5 abort gives no request", req_cnt, r0);
  endtask

  task automatic t_busy();
    bit a0, a1, a2;
    logic [6:0] wm, wa;
    int r0;
    r0 = req_cnt;
    nv_busy = 1'b1;
    tick(4);
    write_reg(8'h00, 8'h05, a0, a1, a2, wm, wa);
    check(!a0 && !a1 && !a2, "R10 nothing acked while busy", {a0, a1, a2}, 0);
    check(busy_drv == 0, "R10 sda released while busy", busy_drv, 0);
    check(wiper_pos == 7'h12, "R10 wiper unchanged while busy", wiper_pos, 7'h12);
    check(req_cnt == r0, "R10 no request while busy", req_cnt, r0);
    nv_busy = 1'b0;
    tick(4*Q);
  endtask

  task automatic t_final_store();
    bit a0, a1, a2;
    logic [6:0] wm, wa;
    write_reg(8'h00, 8'h2A, a0, a1, a2, wm, wa);
    check(wiper_pos == 7'h2A && nv_store_data == 7'h2A, "R3 wiper and start-up value",
          {wiper_pos, nv_store_data}, {7'h2A, 7'h2A});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tick(6);
    rst = 1'b0;
    tick(4);
    t_reset();
    t_store_write();
    t_volatile();
    t_reserved();
    t_bad_id();
    t_abort();
    t_busy();
    t_final_store();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule